// File: doc/BRIEF.md
# Non-Overlapping 1001 Serial Pattern Recognizer

The recognizer takes one serial data bit on each rising clock edge. It raises a single-cycle detect pulse once the bits received since the last restart end in the pattern 1, 0, 0, 1. Matches never overlap. After a hit the recognizer returns to idle, so no bit of a completed match can count toward the next match.

The recognizer keeps its progress in a two-bit state register built from toggle-type flip-flops. A control module works out, for each state bit, whether that bit must flip on this edge. It sends those toggle enables and a hit strobe to a datapath module as one small struct. The datapath holds the toggle register and the registered detect output. The states are numbered in ascending binary order from idle: idle = 00, seen 1 = 01, seen 10 = 10, seen 100 = 11.

Top module: `seqdet_1001`

## Requirements
- R1: While `rst` is high at a rising edge, the state returns to idle (00) and `detect` is 0 after that edge.
- R2: When the state is seen 100 and `serialIn` is 1 at a rising edge, `detect` is 1 for the clock period that follows that edge.
- R3: `detect` is never high for two clock periods in a row.
- R4: After a hit the state returns to idle. The input 1001001 therefore gives exactly one detection, and 10011001 gives exactly two.
- R5: In the seen 1 state, another 1 keeps the state at seen 1. So 11001 is detected once, on its last bit.
- R6: A 0 in the seen 100 state returns to idle, and a 1 in the seen 10 state returns to seen 1. Neither produces a detection.
- R7: `detect` is high only if the four most recent sampled inputs were 1, 0, 0, 1, oldest first.
- R8: A state bit changes only on an edge where its toggle enable is 1. On an edge where its toggle enable is 0, it keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| serialIn | input | 1 | Serial data bit, sampled on each rising edge |
| detect | output | 1 | Registered one-cycle pulse that marks a completed 1001 |

## Verification
The assertions assume that `serialIn` is settled at every rising edge. They also assume that reset is held for at least one edge before any pattern counts, so the four-deep input history behind R7 always lies within the time since reset. The bench changes `serialIn` only on falling edges and holds reset across several edges at the start. It then drives the directed strings for R4 to R6, followed by a long pseudo-random stream. The random stream is weighted toward runs of zeros, so that partial prefixes and restarts after a hit happen often.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_ONE  = 2'b01,
    ST_TEN  = 2'b10,
    ST_HUN  = 2'b11
  } seqState_e;

  typedef struct packed {
    logic [STATE_W-1:0] toggle;
    logic               hitStrobe;
  } seqStrobe_t;

endpackage

// File: rtl/seqdet_ctrl.sv
module seqdet_ctrl
  import seqdet_pkg::*;
(
  input  logic [STATE_W-1:0] stateQ,
  input  logic               serialIn,
  output seqStrobe_t         strobes
);

  seqState_e curState;
  seqState_e nxtState;

  assign curState = seqState_e'(stateQ);

  always_comb begin
    nxtState = ST_IDLE;
    case (curState)
      ST_IDLE: nxtState = serialIn ? ST_ONE : ST_IDLE;
      ST_ONE:  nxtState = serialIn ? ST_ONE : ST_TEN;
      ST_TEN:  nxtState = serialIn ? ST_ONE : ST_HUN;
      ST_HUN:  nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes.toggle    = stateQ ^ STATE_W'(nxtState);
    strobes.hitStrobe = (curState == ST_HUN) && serialIn;
  end

endmodule

// File: rtl/seqdet_dp.sv
module seqdet_dp
  import seqdet_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  seqStrobe_t         strobes,
  output logic [STATE_W-1:0] stateQ,
  output logic               detect
);

  for (genvar gi = 0; gi < STATE_W; gi++) begin : g_tff
    always_ff @(posedge clk) begin
      if (rst)
        stateQ[gi] <= 1'b0;
      else if (strobes.toggle[gi])
        stateQ[gi] <= ~stateQ[gi];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      detect <= 1'b0;
    else
      detect <= strobes.hitStrobe;
  end

endmodule

// File: rtl/seqdet_1001.sv
module seqdet_1001
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic serialIn,
  output logic detect
);

  logic [STATE_W-1:0] stateQ;
  seqStrobe_t         strobes;

  seqdet_ctrl u_ctrl (
    .stateQ   (stateQ),
    .serialIn (serialIn),
    .strobes  (strobes)
  );

  seqdet_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .stateQ  (stateQ),
    .detect  (detect)
  );

endmodule

// File: rtl/seqdet_1001_chk.sv
module seqdet_1001_chk
  import seqdet_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               serialIn,
  input logic               detect,
  input logic [STATE_W-1:0] stateQ,
  input logic [STATE_W-1:0] toggle
);

  // R1: reset clears state and output
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (stateQ == '0) && !detect);

  // R2: seen 100 followed by a 1 gives a pulse
  p_hit_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (stateQ == 2'b11 && serialIn) |=> detect);

  // R3: the pulse lasts one cycle
  p_one_wide_r3: assert property (@(posedge clk) disable iff (rst)
    detect |=> !detect);

  // R4: a hit restarts from idle
  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (stateQ == 2'b11 && serialIn) |=> (stateQ == 2'b00));

  // R5: a repeated 1 holds seen 1
  p_hold_one_r5: assert property (@(posedge clk) disable iff (rst)
    (stateQ == 2'b01 && serialIn) |=> (stateQ == 2'b01));

  // R6: a 0 in seen 100 goes to idle without a pulse
  p_drop_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (stateQ == 2'b11 && !serialIn) |=> (stateQ == 2'b00) && !detect);

  // R7: a pulse needs 1,0,0,1 in the last four samples
  p_history_r7: assert property (@(posedge clk) disable iff (rst)
    detect |-> ($past(serialIn, 1) && !$past(serialIn, 2) &&
                !$past(serialIn, 3) && $past(serialIn, 4)));

  // R8: a bit with its toggle enable low keeps its value
  p_tff_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !toggle[0] |=> $stable(stateQ[0]));
  p_tff_hold_hi_r8: assert property (@(posedge clk) disable iff (rst)
    !toggle[1] |=> $stable(stateQ[1]));

endmodule

bind seqdet_1001 seqdet_1001_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .serialIn (serialIn),
  .detect   (detect),
  .stateQ   (stateQ),
  .toggle   (strobes.toggle)
);

// File: tb/tb_seqdet_1001.sv
module tb_seqdet_1001;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serialIn = 1'b0;
  logic detect;

  int vectors = 0;
  int miscompares = 0;
  int hitsSeen = 0;
  bit expDetect = 1'b0;
  bit since[$];

  seqdet_1001 dut (
    .clk      (clk),
    .rst      (rst),
    .serialIn (serialIn),
    .detect   (detect)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req);
    vectors++;
    if (detect !== expDetect) begin
      miscompares++;
      $display("FAIL %s: detect=%b expected=%b at %0t", req, detect, expDetect, $time);
    end
    if (detect === 1'b1) hitsSeen++;
  endtask

  // Behavioural model: the bits since the last restart, matched on their tail
  task automatic applyBit(input bit b, input string req);
    int n;
    @(negedge clk);
    check(req);
    serialIn = b;
    since.push_back(b);
    n = since.size();
    if (n >= 4 && since[n-4] && !since[n-3] && !since[n-2] && since[n-1]) begin
      expDetect = 1'b1;
      since.delete();
    end else begin
      expDetect = 1'b0;
    end
  endtask

  task automatic applyString(input string s, input string req);
    for (int i = 0; i < s.len(); i++) applyBit(s[i] == "1", req);
    @(negedge clk);
    check(req);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    serialIn = 1'b1;
    repeat (3) @(negedge clk);
    expDetect = 1'b0;
    since.delete();
    check("R1");
    rst = 1'b0;
    serialIn = 1'b0;
  endtask

  task automatic countCheck(input int got, input int want, input string req);
    vectors++;
    if (got != want) begin
      miscompares++;
      $display("FAIL %s: detections=%0d expected=%0d", req, got, want);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    doReset();
    applyString("0000", "R1");

    doReset(); hitsSeen = 0;
    applyString("1001", "R2");
    countCheck(hitsSeen, 1, "R2");

    doReset(); hitsSeen = 0;
    applyString("1001001", "R4");
    countCheck(hitsSeen, 1, "R4");

    doReset(); hitsSeen = 0;
    applyString("10011001", "R4");
    countCheck(hitsSeen, 2, "R4");

    doReset(); hitsSeen = 0;
    applyString("11001", "R5");
    countCheck(hitsSeen, 1, "R5");

    doReset(); hitsSeen = 0;
    applyString("10001011000", "R6");
    countCheck(hitsSeen, 0, "R6");

    doReset(); hitsSeen = 0;
    applyString("100110011001", "R3");
    countCheck(hitsSeen, 3, "R3");

    // Reset in the middle of a prefix: the next match must start over
    doReset(); hitsSeen = 0;
    applyString("100", "R1");
    doReset();
    applyString("1001", "R1");
    countCheck(hitsSeen, 1, "R1");

    doReset();
    for (int i = 0; i < 3000; i++) begin
      applyBit(($urandom % 5) < 2, "R7");
    end
    @(negedge clk);
    check("R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule